// File: doc/BRIEF.md
# Reset Mode Capture and Breakpoint Routing

This block records configuration pin levels while the chip is held in reset. A shared clock-mode pad selects the clock source. A high level picks the synthesizer output, which is derived from the reference frequency. A low level turns the synthesizer off and selects an external system clock. Two active-low breakpoint inputs, one internal and one external, are sampled as reset is released. If either is low at that point, a background-debug flag is set and held.

After reset, each new assertion of either breakpoint input is routed to one of two outputs. With the debug flag set it becomes a debug-entry request; with the flag clear it becomes a breakpoint-exception request. The clock-mode pad is then handed back to the general-purpose port. Its output driver stays off during reset, and afterwards it follows the port's direction and data bits.

Top module: `reset_mode_capture`

## Requirements
- R1: While `rst_n` is low, `synth_sel_o` follows the clock-mode pad level: 1 selects the synthesizer, 0 selects the external clock. The value present on the last reset cycle is the one kept.
- R2: After `rst_n` rises, `synth_sel_o` and `bgnd_en_o` hold their captured values until the next reset, whatever the pads do.
- R3: `bgnd_en_o` is 1 when `bkpt_int_n` or `bkpt_ext_n` is low at reset release. It is 0 when both are high.
- R4: With `bgnd_en_o` = 1, a high-to-low transition on either breakpoint input makes `dbg_entry_o` high for one cycle, and `brk_exc_o` stays low. The pulse is seen after the third rising clock edge following the transition.
- R5: With `bgnd_en_o` = 0, the same transition makes `brk_exc_o` high for one cycle with the same latency, and `dbg_entry_o` stays low.
- R6: No request is produced while `rst_n` is low. A breakpoint input held low through reset release produces no request, because no transition occurs.
- R7: `cfg_pad_oe_o` is 0 while `rst_n` is low. After reset it equals `gp_dir_i`, where 1 means output. `cfg_pad_do_o` always equals `gp_dout_i`.
- R8: `gp_din_o` shows the clock-mode pad level two rising edges after the pad changes.
- R9: A breakpoint input that stays low yields only one pulse. A further request needs the input to go high and then fall again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| cfg_pad_i | input | 1 | Clock-mode / port pad input level |
| bkpt_int_n | input | 1 | Internal breakpoint, active low |
| bkpt_ext_n | input | 1 | External breakpoint, active low |
| gp_dir_i | input | 1 | Port direction bit (1 = output) |
| gp_dout_i | input | 1 | Port output data bit |
| gp_din_o | output | 1 | Synchronized pad level for the port |
| cfg_pad_oe_o | output | 1 | Pad output enable |
| cfg_pad_do_o | output | 1 | Pad output data |
| synth_sel_o | output | 1 | 1 = synthesizer clock, 0 = external clock |
| bgnd_en_o | output | 1 | Background-debug flag |
| dbg_entry_o | output | 1 | One-cycle debug-entry request |
| brk_exc_o | output | 1 | One-cycle breakpoint-exception request |

## Verification
Each stimulus is applied on a falling clock edge, and each result is read on a later falling edge.

- Requests go high after the third rising edge following a breakpoint transition, so they are checked low on the first and second falling edges and high on the third. They are checked low again on the fourth falling edge, which confirms the pulse lasts one cycle.
- `gp_din_o` is checked unchanged one edge after a pad change and updated after two.
- The captured values are held pads stable for several reset cycles before release. They are read back after the pads are changed, which shows they were held.
- `cfg_pad_oe_o` and `cfg_pad_do_o` are combinational and are checked in the same half cycle as the change that drives them.

// File: rtl/reset_mode_capture.sv
module reset_mode_capture #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_pad_i,
  input  logic bkpt_int_n,
  input  logic bkpt_ext_n,
  input  logic gp_dir_i,
  input  logic gp_dout_i,
  output logic gp_din_o,
  output logic cfg_pad_oe_o,
  output logic cfg_pad_do_o,
  output logic synth_sel_o,
  output logic bgnd_en_o,
  output logic dbg_entry_o,
  output logic brk_exc_o
);

  localparam int NPIN   = 3;
  localparam int PAD    = 2;
  localparam int LAST   = SYNC_STAGES - 1;

  logic [NPIN-1:0] sync_q [SYNC_STAGES];
  logic [NPIN-1:0] cur;
  logic [1:0]      bk_prev;
  logic [1:0]      bk_fall;
  logic            any_fall;

  always_ff @(posedge clk) begin
    sync_q[0] <= {cfg_pad_i, bkpt_ext_n, bkpt_int_n};
    for (int i = 1; i < SYNC_STAGES; i++)
      sync_q[i] <= sync_q[i-1];
  end

  assign cur      = sync_q[LAST];
  assign bk_fall  = bk_prev & ~cur[1:0];
  assign any_fall = |bk_fall;

  always_ff @(posedge clk) bk_prev <= cur[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      synth_sel_o <= cur[PAD];
      bgnd_en_o   <= ~&cur[1:0];
      dbg_entry_o <= 1'b0;
      brk_exc_o   <= 1'b0;
    end else begin
      dbg_entry_o <= any_fall & bgnd_en_o;
      brk_exc_o   <= any_fall & ~bgnd_en_o;
    end
  end

  assign gp_din_o     = cur[PAD];
  assign cfg_pad_oe_o = rst_n & gp_dir_i;
  assign cfg_pad_do_o = gp_dout_i;

  // R2
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($stable(synth_sel_o) && $stable(bgnd_en_o)));

  // R6
  no_req_in_reset_chk: assert property (@(posedge clk)
    !rst_n |=> (!dbg_entry_o && !brk_exc_o));

  // R4
  dbg_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_entry_o |-> (bgnd_en_o && !brk_exc_o));

  // R5
  exc_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_exc_o |-> (!bgnd_en_o && !dbg_entry_o));

  // R9
  dbg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_entry_o |=> !dbg_entry_o);

  // R9
  exc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_exc_o |=> !brk_exc_o);

endmodule

// File: tb/reset_mode_capture_test.sv
module reset_mode_capture_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pad = 1'b0, bi = 1'b1, be = 1'b1, dir = 1'b0, dout = 1'b0;
  logic din, oe, dov, ssel, bgnd, dreq, ereq;
  int total = 0, fails = 0;

  always #10 clk = ~clk;

  reset_mode_capture uut (
    .clk(clk), .rst_n(rst_n), .cfg_pad_i(pad), .bkpt_int_n(bi), .bkpt_ext_n(be),
    .gp_dir_i(dir), .gp_dout_i(dout), .gp_din_o(din), .cfg_pad_oe_o(oe),
    .cfg_pad_do_o(dov), .synth_sel_o(ssel), .bgnd_en_o(bgnd),
    .dbg_entry_o(dreq), .brk_exc_o(ereq));

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic enter_reset(input logic p, input logic i, input logic e);
    @(negedge clk);
    rst_n = 1'b0; pad = p; bi = i; be = e;
    repeat (6) @(negedge clk);
  endtask

  task automatic release_reset;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // drive one input low at a negedge and check the pulse window
  task automatic fire(input bit use_ext, input logic exp_d, input logic exp_e, input string req);
    @(negedge clk);
    if (use_ext) be = 1'b0; else bi = 1'b0;
    repeat (2) begin
      @(negedge clk);
      check(req, dreq | ereq, 1'b0);
    end
    @(negedge clk);
    check(req, dreq, exp_d);
    check(req, ereq, exp_e);
    @(negedge clk);
    check({req, " R9"}, dreq | ereq, 1'b0);
  endtask

  task automatic t_reset_state;
    enter_reset(1'b1, 1'b1, 1'b1);
    dir = 1'b1; dout = 1'b1;
    @(negedge clk);
    check("R7 oe in reset", oe, 1'b0);
    check("R7 do", dov, 1'b1);
    check("R6 no dbg in reset", dreq, 1'b0);
    check("R6 no exc in reset", ereq, 1'b0);
    check("R1 sel synth", ssel, 1'b1);
    pad = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 sel follows pad in reset", ssel, 1'b0);
    bi = 1'b0;
    repeat (4) @(negedge clk);
    bi = 1'b1;
    repeat (4) @(negedge clk);
    check("R6 toggle in reset dbg", dreq, 1'b0);
    check("R6 toggle in reset exc", ereq, 1'b0);
    dir = 1'b0;
  endtask

  task automatic t_exception_mode;
    enter_reset(1'b1, 1'b1, 1'b1);
    release_reset();
    check("R1 synth kept", ssel, 1'b1);
    check("R3 flag clear", bgnd, 1'b0);
    fire(1'b1, 1'b0, 1'b1, "R5 ext exc");
    repeat (3) @(negedge clk);
    check("R9 held low no repeat", ereq, 1'b0);
    be = 1'b1;
    repeat (3) @(negedge clk);
    fire(1'b0, 1'b0, 1'b1, "R5 int exc");
    bi = 1'b1;
    pad = 1'b0;
    @(negedge clk);
    check("R8 din old", din, 1'b1);
    @(negedge clk);
    check("R8 din new", din, 1'b0);
    repeat (2) @(negedge clk);
    check("R2 sel held", ssel, 1'b1);
    dir = 1'b1;
    #1 check("R7 oe after reset", oe, 1'b1);
    dir = 1'b0;
    #1 check("R7 oe input", oe, 1'b0);
  endtask

  task automatic t_debug_mode_ext;
    enter_reset(1'b0, 1'b1, 1'b0);
    release_reset();
    check("R1 external kept", ssel, 1'b0);
    check("R3 flag set ext", bgnd, 1'b1);
    repeat (4) begin
      @(negedge clk);
      check("R6 held through release", dreq | ereq, 1'b0);
    end
    be = 1'b1;
    repeat (3) @(negedge clk);
    fire(1'b0, 1'b1, 1'b0, "R4 int dbg");
    bi = 1'b1;
    repeat (3) @(negedge clk);
    fire(1'b1, 1'b1, 1'b0, "R4 ext dbg");
    be = 1'b1; pad = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 flag held", bgnd, 1'b1);
    check("R2 sel held ext", ssel, 1'b0);
  endtask

  task automatic t_debug_mode_int;
    enter_reset(1'b1, 1'b0, 1'b1);
    release_reset();
    check("R3 flag set int", bgnd, 1'b1);
    bi = 1'b1;
    repeat (3) @(negedge clk);
    fire(1'b1, 1'b1, 1'b0, "R4 ext dbg2");
    be = 1'b1;
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_exception_mode();
        t_debug_mode_ext();
        t_debug_mode_int();
      end
      begin
        repeat (20000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule